// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Controller

This block is the shared control section of a multi-channel pulse-width modulator. It sits behind a simple memory-mapped register port. It keeps one run bit per channel and one interrupt-mask bit per channel. Software never writes these bits directly. It changes them through paired set and clear strobes: writing ones to a "turn on" register sets the matching bits, and writing ones to a "turn off" register clears them. The run bits are driven out to the channel counters and can also be read back through a status register.

Each channel counter reports the end of every one of its periods with a single-cycle event pulse. When that channel's mask bit is set, the event latches a pending flag. The single interrupt line is high whenever a pending flag meets a set mask bit. Reading the pending register returns the flags and acknowledges them in the same access. An event that arrives during that read is kept for the next read.

A window of addresses above the global registers is divided into equal slices, one per channel. An access that falls in a slice is passed on to that channel's private register logic with a one-hot select and the offset within the slice. The read data comes back from that channel.

Top module: `pwm_ctrl_top`

## Requirements
- R1: After synchronous reset all run bits, mask bits and pending bits are 0, the interrupt line is low, and the mode word reads 0.
- R2: A write to offset 0x04 sets every run bit n whose data bit n is 1 and leaves all other run bits unchanged. The new value appears on `chan_en` and in the status register at offset 0x0C from the next cycle.
- R3: A write to offset 0x08 clears every run bit n whose data bit n is 1 and leaves all other run bits unchanged.
- R4: A write to offset 0x10 sets, and a write to offset 0x14 clears, mask bit n for each data bit n that is 1. Offset 0x18 reads back the current mask.
- R5: An event on `period_end[n]` sets pending bit n in the next cycle only if mask bit n is 1. Events on channels whose mask bit is 0 are dropped. Pending bits accumulate until they are read.
- R6: A read of offset 0x1C returns the pending bits and clears exactly those bits. An event that is latched in the same cycle as the read stays pending afterwards.
- R7: `irq` is high exactly when some channel has both its pending bit and its mask bit set. Clearing a mask bit does not discard that channel's pending bit.
- R8: Offset 0x00 is a read/write mode word that is driven unchanged on `mode_cfg`.
- R9: An access at 0x200 + n*0x20 + k, for channel n below the channel count and k below 0x20, raises only `chan_sel[n]`, presents k on `chan_off`, and raises `chan_wr` for writes. A read returns that channel's slice of `chan_rdata`. Outside this window `chan_sel` is all zero.
- R10: Writes to offsets 0x0C, 0x18 and 0x1C change nothing. Reads of 0x04, 0x08, 0x10, 0x14 and of unmapped offsets return 0. Status, mask and pending reads return 0 above the channel count.
- R11: No register changes while `bus_sel` is low, whatever the other bus inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| period_end | input | NCH | One-cycle end-of-period event per channel |
| chan_en | output | NCH | Run bit per channel |
| mode_cfg | output | 32 | Mode word |
| irq | output | 1 | Combined interrupt request |
| chan_sel | output | NCH | One-hot select of the addressed channel slice |
| chan_wr | output | 1 | Write into the selected channel slice |
| chan_off | output | OFF_W | Byte offset inside the channel slice |
| chan_wdata | output | 32 | Write data forwarded to the channel |
| chan_rdata | input | NCH*32 | Read data from every channel, channel n in bits 32n+31..32n |

## Verification
The properties assume at most one access per cycle, with `bus_wr` meaningful only while `bus_sel` is high. They also assume that `period_end` carries single-cycle pulses, which can coincide with any access, including a pending read. The stimulus issues one access per task call and returns `bus_sel` low between accesses. It drives events either on their own or deliberately in the same cycle as a pending read. The sweeps cover every pair of 4-bit set and clear patterns, and every pairing of event pattern with mask pattern.

// File: rtl/pwmctl_pkg.sv
// Package: shared offsets and the decoded-register type for the PWM
// control block. Assumes a 32-bit register data path.
package pwmctl_pkg;
    localparam int REG_DW     = 32;
    localparam int OFS_MODE   = 'h00;
    localparam int OFS_RUN    = 'h04;
    localparam int OFS_STOP   = 'h08;
    localparam int OFS_STAT   = 'h0C;
    localparam int OFS_MSET   = 'h10;
    localparam int OFS_MCLR   = 'h14;
    localparam int OFS_MASK   = 'h18;
    localparam int OFS_PEND   = 'h1C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_MODE,
        RG_RUN,
        RG_STOP,
        RG_STAT,
        RG_MSET,
        RG_MCLR,
        RG_MASK,
        RG_PEND,
        RG_CHAN
    } reg_sel_e;
endpackage

// File: rtl/pwmctl_decode.sv
// Module: address decoder. Maps a byte offset to one global register or
// to a channel slice of the private-register window.
// Assumes: WIN_BASE lies above the global registers and CH_STRIDE is a
// power of two; purely combinational.
module pwmctl_decode
    import pwmctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NCH       = 4,
    parameter int WIN_BASE  = 'h200,
    parameter int CH_STRIDE = 32,
    localparam int OFF_W    = $clog2(CH_STRIDE)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          hit,
    output logic [NCH-1:0]    chan_hit,
    output logic [OFF_W-1:0]  chan_off
);
    localparam int IDX_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] rel;
    logic              in_win;

    // Offset relative to the window start and window membership.
    assign rel      = addr - ADDR_W'(WIN_BASE);
    assign in_win   = (addr >= ADDR_W'(WIN_BASE)) &&
                      (rel < ADDR_W'(NCH * CH_STRIDE));
    assign chan_off = rel[OFF_W-1:0];

    // One comparator per channel slice.
    for (genvar g = 0; g < NCH; g++) begin : g_slice
        assign chan_hit[g] = in_win && (rel[ADDR_W-1:OFF_W] == IDX_W'(g));
    end

    // Global register lookup, falling back to the channel window.
    always_comb begin
        case (addr)
            ADDR_W'(OFS_MODE): hit = RG_MODE;
            ADDR_W'(OFS_RUN):  hit = RG_RUN;
            ADDR_W'(OFS_STOP): hit = RG_STOP;
            ADDR_W'(OFS_STAT): hit = RG_STAT;
            ADDR_W'(OFS_MSET): hit = RG_MSET;
            ADDR_W'(OFS_MCLR): hit = RG_MCLR;
            ADDR_W'(OFS_MASK): hit = RG_MASK;
            ADDR_W'(OFS_PEND): hit = RG_PEND;
            default:           hit = in_win ? RG_CHAN : RG_NONE;
        endcase
    end
endmodule

// File: rtl/pwmctl_setclr.sv
// Module: bank of N bits driven by write-one-to-set and write-one-to-clear
// strobes. Assumes the strobes are already qualified with the access;
// if both hit the same bit, clear wins.
module pwmctl_setclr #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] state_q
);
    // Apply set then clear each cycle; reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= (state_q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/pwmctl_pending.sv
// Module: pending-event latch with clear-on-read and masked interrupt.
// Assumes ack is high for exactly the cycle in which the pending value is
// returned to the bus; events of that same cycle survive the ack.
module pwmctl_pending #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic         ack,
    output logic [N-1:0] pend_q,
    output logic         irq
);
    logic [N-1:0] captured;
    logic [N-1:0] kept;

    // Only events of masked-in channels are captured.
    assign captured = evt & mask;
    // An acknowledge drops exactly the bits visible to the reader.
    assign kept     = ack ? '0 : pend_q;

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= kept | captured;
    end

    // Interrupt request from pending-and-enabled channels.
    assign irq = |(pend_q & mask);
endmodule

// File: rtl/pwm_ctrl_top.sv
// Module: global control block of a multi-channel PWM. Decodes the
// register port, holds run bits, interrupt mask, pending events and the
// mode word, and forwards the per-channel window to channel logic.
// Assumes one access per cycle and single-cycle period-end pulses.
module pwm_ctrl_top
    import pwmctl_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int ADDR_W    = 12,
    parameter int WIN_BASE  = 'h200,
    parameter int CH_STRIDE = 32,
    localparam int OFF_W    = $clog2(CH_STRIDE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_DW-1:0]     bus_wdata,
    output logic [REG_DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]        period_end,
    output logic [NCH-1:0]        chan_en,
    output logic [REG_DW-1:0]     mode_cfg,
    output logic                  irq,
    output logic [NCH-1:0]        chan_sel,
    output logic                  chan_wr,
    output logic [OFF_W-1:0]      chan_off,
    output logic [REG_DW-1:0]     chan_wdata,
    input  logic [NCH*REG_DW-1:0] chan_rdata
);
    reg_sel_e          hit;
    logic [NCH-1:0]    chan_hit;
    logic              wr_stb;
    logic              rd_stb;
    logic [NCH-1:0]    wbits;
    logic [NCH-1:0]    run_set, run_clr, msk_set, msk_clr;
    logic [NCH-1:0]    mask_q;
    logic [NCH-1:0]    pend_q;
    logic              pend_ack;
    logic [REG_DW-1:0] mode_q;
    logic [REG_DW-1:0] chan_rd_mux;

    pwmctl_decode #(
        .ADDR_W   (ADDR_W),
        .NCH      (NCH),
        .WIN_BASE (WIN_BASE),
        .CH_STRIDE(CH_STRIDE)
    ) u_dec (
        .addr    (bus_addr),
        .hit     (hit),
        .chan_hit(chan_hit),
        .chan_off(chan_off)
    );

    // Qualified access strobes.
    assign wr_stb = bus_sel && bus_wr;
    assign rd_stb = bus_sel && !bus_wr;
    assign wbits  = bus_wdata[NCH-1:0];

    // Set and clear strobes for the two bit banks.
    assign run_set = (wr_stb && hit == RG_RUN)  ? wbits : '0;
    assign run_clr = (wr_stb && hit == RG_STOP) ? wbits : '0;
    assign msk_set = (wr_stb && hit == RG_MSET) ? wbits : '0;
    assign msk_clr = (wr_stb && hit == RG_MCLR) ? wbits : '0;

    pwmctl_setclr #(.N(NCH)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(run_set),
        .clr_bits(run_clr),
        .state_q (chan_en)
    );

    pwmctl_setclr #(.N(NCH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(msk_set),
        .clr_bits(msk_clr),
        .state_q (mask_q)
    );

    // Pending register acknowledged by its own read.
    assign pend_ack = rd_stb && (hit == RG_PEND);

    pwmctl_pending #(.N(NCH)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (period_end),
        .mask  (mask_q),
        .ack   (pend_ack),
        .pend_q(pend_q),
        .irq   (irq)
    );

    // Mode word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mode_q <= '0;
        else if (wr_stb && hit == RG_MODE) mode_q <= bus_wdata;
    end
    assign mode_cfg = mode_q;

    // Select the read data of the addressed channel slice.
    always_comb begin
        chan_rd_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan_hit[i]) chan_rd_mux = chan_rdata[i*REG_DW +: REG_DW];
        end
    end

    // Channel window forwarding.
    assign chan_sel   = bus_sel ? chan_hit : '0;
    assign chan_wr    = wr_stb && (|chan_hit);
    assign chan_wdata = bus_wdata;

    // Read data multiplexer for the access cycle.
    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (hit)
                RG_MODE: bus_rdata = mode_q;
                RG_STAT: bus_rdata = REG_DW'(chan_en);
                RG_MASK: bus_rdata = REG_DW'(mask_q);
                RG_PEND: bus_rdata = REG_DW'(pend_q);
                RG_CHAN: bus_rdata = chan_rd_mux;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwmctl_checker.sv
// Module: protocol checker for pwm_ctrl_top, attached by bind.
// Assumes one access per cycle and that the top's mask and pending
// registers are visible under the names mask_q and pend_q.
module pwmctl_checker
    import pwmctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCH-1:0]    wbits,
    input logic [NCH-1:0]    period_end,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    mask_q,
    input logic [NCH-1:0]    pend_q,
    input logic [NCH-1:0]    chan_sel,
    input logic              irq
);
    logic wr_run, wr_stop, wr_mset, wr_mclr, rd_pend;
    assign wr_run  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_RUN);
    assign wr_stop = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_STOP);
    assign wr_mset = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_MSET);
    assign wr_mclr = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_MCLR);
    assign rd_pend = bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_PEND);

    p_run_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_run |=> ((chan_en & $past(wbits)) == $past(wbits)) &&
                   ((chan_en & ~$past(wbits)) == ($past(chan_en) & ~$past(wbits))));

    p_run_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> ((chan_en & $past(wbits)) == '0) &&
                    ((chan_en & ~$past(wbits)) == ($past(chan_en) & ~$past(wbits))));

    p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(wbits)) == $past(wbits)));

    p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(wbits)) == '0));

    p_evt_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((period_end & mask_q) != '0) |=>
            ((pend_q & $past(period_end & mask_q)) == $past(period_end & mask_q)));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && period_end == '0) |=> (pend_q == '0));

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_pend && !wr_mclr) |=> irq);

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));

    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(chan_en) && $stable(mask_q));
endmodule

bind pwm_ctrl_top pwmctl_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wbits     (bus_wdata[NCH-1:0]),
    .period_end(period_end),
    .chan_en   (chan_en),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .chan_sel  (chan_sel),
    .irq       (irq)
);

// File: tb/tb_pwm_ctrl_top.sv
module tb_pwm_ctrl_top;
    localparam int NCH    = 4;
    localparam int ADDR_W = 12;
    localparam int OFF_W  = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_sel = 1'b0;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NCH-1:0]      period_end = '0;
    logic [NCH-1:0]      chan_en;
    logic [31:0]         mode_cfg;
    logic                irq;
    logic [NCH-1:0]      chan_sel;
    logic                chan_wr;
    logic [OFF_W-1:0]    chan_off;
    logic [31:0]         chan_wdata;
    logic [NCH*32-1:0]   chan_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    for (genvar g = 0; g < NCH; g++) begin : g_crd
        assign chan_rdata[g*32 +: 32] = 32'hC0DE_0000 | (32'(g) << 8) | 32'h5A;
    end

    pwm_ctrl_top #(.NCH(NCH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .period_end(period_end), .chan_en(chan_en), .mode_cfg(mode_cfg),
        .irq(irq), .chan_sel(chan_sel), .chan_wr(chan_wr), .chan_off(chan_off),
        .chan_wdata(chan_wdata), .chan_rdata(chan_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input int addr, input logic [NCH-1:0] evt, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr); period_end = evt;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; period_end = '0;
    endtask

    task automatic pulse(input logic [NCH-1:0] evt);
        @(negedge clk);
        period_end = evt;
        @(negedge clk);
        period_end = '0;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [3:0]  m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 chan_en", 32'(chan_en), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 mode_cfg", mode_cfg, 0);
        bread('h0C, 0, rd); chk("R1 status", rd, 0);
        bread('h18, 0, rd); chk("R1 mask", rd, 0);
        bread('h1C, 0, rd); chk("R1 pending", rd, 0);

        // R2 and R3: every pair of start value and set/clear pattern
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                bwrite('h08, 32'hF);
                bwrite('h04, 32'(a));
                bwrite('h04, 32'(b) | 32'hFFFF_FFF0);
                #1 chk("R2 chan_en after set", 32'(chan_en), 32'(a | b));
                bwrite('h08, 32'(a));
                bread('h0C, 0, rd);
                chk("R3 status after clear", rd, 32'((a | b) & ~a & 4'hF));
            end
        end

        // R4: mask set/clear sweep with readback
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                bwrite('h14, 32'hF);
                bwrite('h10, 32'(a));
                bwrite('h10, 32'(b));
                bread('h18, 0, rd);
                chk("R4 mask after set", rd, 32'(a | b));
                bwrite('h14, 32'(b));
                bread('h18, 0, rd);
                chk("R4 mask after clear", rd, 32'((a | b) & ~b & 4'hF));
            end
        end

        // R5: every event pattern against every mask pattern
        for (int mk = 0; mk < 16; mk++) begin
            for (int e = 0; e < 16; e++) begin
                m = 4'(mk);
                bwrite('h14, 32'hF);
                bwrite('h10, 32'(m));
                bread('h1C, 0, rd);
                pulse(4'(e));
                chk("R5 irq after event", 32'(irq), 32'(|(4'(e) & m)));
                bread('h1C, 0, rd);
                chk("R5 pending capture", rd, 32'(4'(e) & m));
            end
        end

        // R5: accumulation across events
        bwrite('h10, 32'hF);
        bread('h1C, 0, rd);
        pulse(4'h1);
        pulse(4'h8);
        bread('h1C, 0, rd);
        chk("R5 accumulate", rd, 32'h9);

        // R6: event in the same cycle as the pending read survives
        pulse(4'h3);
        bread('h1C, 4'h4, rd);
        chk("R6 read returns old", rd, 32'h3);
        bread('h1C, 0, rd);
        chk("R6 same-cycle event kept", rd, 32'h4);
        bread('h1C, 0, rd);
        chk("R6 cleared after read", rd, 32'h0);
        #1 chk("R6 irq low after ack", 32'(irq), 0);

        // R7: mask gating keeps pending
        pulse(4'h2);
        chk("R7 irq set", 32'(irq), 1);
        bwrite('h14, 32'h2);
        #1 chk("R7 irq masked off", 32'(irq), 0);
        bwrite('h10, 32'h2);
        #1 chk("R7 irq back, pending kept", 32'(irq), 1);
        bread('h1C, 0, rd);
        chk("R7 pending value", rd, 32'h2);
        #1 chk("R7 irq after ack", 32'(irq), 0);

        // R8: mode word
        bwrite('h00, 32'hA5A5_1234);
        #1 chk("R8 mode_cfg", mode_cfg, 32'hA5A5_1234);
        bread('h00, 0, rd);
        chk("R8 mode read", rd, 32'hA5A5_1234);

        // R9: channel window, every slice and every word offset
        for (int n = 0; n < NCH; n++) begin
            for (int k = 0; k < 32; k += 4) begin
                @(negedge clk);
                bus_sel = 1'b1; bus_wr = 1'b0;
                bus_addr = ADDR_W'('h200 + n * 'h20 + k);
                #1;
                chk("R9 read data", bus_rdata, 32'hC0DE_005A | (32'(n) << 8));
                chk("R9 chan_sel", 32'(chan_sel), 32'(1) << n);
                chk("R9 chan_off", 32'(chan_off), 32'(k));
                chk("R9 chan_wr on read", 32'(chan_wr), 0);
                bus_wr = 1'b1; bus_wdata = 32'(n * 100 + k);
                #0.5;
                chk("R9 chan_wr on write", 32'(chan_wr), 1);
                chk("R9 chan_wdata", chan_wdata, 32'(n * 100 + k));
                @(negedge clk);
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
        end
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'('h280);
        #1 chk("R9 above window sel", 32'(chan_sel), 0);
        chk("R9 above window data", bus_rdata, 0);
        bus_addr = ADDR_W'('h1FC);
        #1 chk("R9 below window sel", 32'(chan_sel), 0);
        @(negedge clk);
        bus_sel = 1'b0;

        // R10: read-only and write-only behaviour
        bwrite('h08, 32'hF);
        bwrite('h04, 32'h5);
        bwrite('h0C, 32'hF);
        bread('h0C, 0, rd); chk("R10 status write ignored", rd, 32'h5);
        bwrite('h14, 32'hF);
        bwrite('h10, 32'h6);
        bwrite('h18, 32'h9);
        bread('h18, 0, rd); chk("R10 mask write ignored", rd, 32'h6);
        bread('h1C, 0, rd);
        bwrite('h1C, 32'hF);
        bread('h1C, 0, rd); chk("R10 pending write ignored", rd, 32'h0);
        bread('h04, 0, rd); chk("R10 run reg reads 0", rd, 0);
        bread('h08, 0, rd); chk("R10 stop reg reads 0", rd, 0);
        bread('h10, 0, rd); chk("R10 mset reads 0", rd, 0);
        bread('h14, 0, rd); chk("R10 mclr reads 0", rd, 0);
        bread('h40, 0, rd); chk("R10 unmapped reads 0", rd, 0);

        // R11: nothing changes without bus_sel
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = ADDR_W'('h04); bus_wdata = 32'hF;
        @(negedge clk);
        bus_addr = ADDR_W'('h10);
        @(negedge clk);
        bus_addr = ADDR_W'('h00);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 chk("R11 chan_en unchanged", 32'(chan_en), 32'h5);
        chk("R11 mode unchanged", mode_cfg, 32'hA5A5_1234);
        bread('h18, 0, rd); chk("R11 mask unchanged", rd, 32'h6);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule